// File: doc/BRIEF.md
# Split-Stream Dual Program Counter Sequencer

This block keeps the two program counters behind a single logical instruction stream that is stored as two physical half-bundle streams. The execution-side counter climbs toward higher addresses and the flow-side counter descends toward lower addresses. Both start from a shared entry point, so the flow half-bundles sit just below it in memory and the execution half-bundles sit at and above it. Every cycle, each stream that issues moves its counter by the byte length of the half-bundle it has just consumed. That length is reported by the decoder from the half-bundle header.

Empty cycles are not encoded as explicit no-ops. A half-bundle can carry a skip count in its alignment padding, and that count tells the sequencer how many of the following cycles the opposite stream has no work. While a stream is idle it issues nothing and its counter holds. A taken control transfer loads both counters with the same target and drops any pending skip counts. The target must be the entry point of a single-entry, multiple-exit block. A stall freezes all of the block's state.

Top module: `dual_stream_seq`

## Requirements
- R1: After reset, `exuAddr` equals `RESET_ADDR`, `flowAddr` equals `RESET_ADDR - 1`, and both issue flags are 1 while `stall` is 0.
- R2: In a cycle where `exuIssue` is 1 and `branchValid` is 0, `exuAddr` increases by `exuLen` in the next cycle.
- R3: `flowAddr` is the byte just below the flow counter. In a cycle where `flowIssue` is 1 and `branchValid` is 0, it decreases by `flowLen` in the next cycle.
- R4: When `branchValid` is 1 and `stall` is 0, the next cycle shows `exuAddr` equal to `branchTarget` and `flowAddr` equal to `branchTarget - 1`.
- R5: A taken branch cancels pending skip counts on both streams, so both issue flags are 1 in the next unstalled cycle.
- R6: When the execution stream issues with a nonzero `exuSkip` of k while the flow stream has no pending skip, `flowIssue` is 0 for the next k unstalled cycles and then returns to 1.
- R7: When the flow stream issues with a nonzero `flowSkip` of k while the execution stream has no pending skip, `exuIssue` is 0 for the next k unstalled cycles and then returns to 1.
- R8: A skip field is ignored when the stream that carries it does not issue, or when the opposite stream already has a pending skip. A pending count is neither extended nor replaced.
- R9: A stream whose issue flag is 0 keeps its fetch address unchanged into the next cycle.
- R10: While `stall` is 1, both issue flags are 0, both addresses and both pending skip counts hold, and `branchValid` has no effect.
- R11: Address arithmetic wraps modulo 2^`ADDR_W`. A target of 0 gives a `flowAddr` of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freeze all sequencing state this cycle |
| branchValid | input | 1 | Control transfer taken this cycle |
| branchTarget | input | ADDR_W | Entry-point address of the transfer |
| exuLen | input | LEN_W | Byte length of the execution half-bundle issued this cycle |
| flowLen | input | LEN_W | Byte length of the flow half-bundle issued this cycle |
| exuSkip | input | SKIP_W | Idle-cycle count for the flow stream, taken from the execution half-bundle padding |
| flowSkip | input | SKIP_W | Idle-cycle count for the execution stream, taken from the flow half-bundle padding |
| exuAddr | output | ADDR_W | Execution-stream fetch address |
| flowAddr | output | ADDR_W | Flow-stream fetch address (counter minus one) |
| exuIssue | output | 1 | Execution half-bundle issues this cycle |
| flowIssue | output | 1 | Flow half-bundle issues this cycle |

## Verification
The bench goes after the following cases:
- Skip counts arriving while the opposite stream is already idle. A design that reloads here would stretch or cut short an idle window.
- Both streams idle at once. A design that gates one counter's decrement on the other stream would deadlock.
- Stalls in the middle of a skip window. A design that keeps counting through a stall would shorten the window.
- A branch taken while a skip is pending. A design that failed to clear the count would leave a stream mute at the new entry point.
- Branches to address 0 and just below the top of the address space. A design with width or sign slips would give a wrong flow address or lose the carry.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef struct packed {
    logic load;
    logic advExu;
    logic advFlow;
  } seqStrobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int SKIP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  logic              branchValid,
  input  logic [SKIP_W-1:0] exuSkip,
  input  logic [SKIP_W-1:0] flowSkip,
  output seqStrobe_t        strobe,
  output logic              exuIssue,
  output logic              flowIssue
);
  // cycles each stream must still sit out
  logic [SKIP_W-1:0] exuIdle, flowIdle;
  logic [SKIP_W-1:0] exuIdleNext, flowIdleNext;

  assign exuIssue  = !stall && (exuIdle == '0);
  assign flowIssue = !stall && (flowIdle == '0);

  always_comb begin
    exuIdleNext  = exuIdle;
    flowIdleNext = flowIdle;
    if (!stall) begin
      if (branchValid) begin
        exuIdleNext  = '0;
        flowIdleNext = '0;
      end else begin
        // a pending window runs down; only an empty window accepts a new count
        if (flowIdle != '0)  flowIdleNext = flowIdle - 1'b1;
        else if (exuIssue)   flowIdleNext = exuSkip;
        if (exuIdle != '0)   exuIdleNext  = exuIdle - 1'b1;
        else if (flowIssue)  exuIdleNext  = flowSkip;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exuIdle  <= '0;
      flowIdle <= '0;
    end else begin
      exuIdle  <= exuIdleNext;
      flowIdle <= flowIdleNext;
    end
  end

  always_comb begin
    strobe.load    = !stall && branchValid;
    strobe.advExu  = exuIssue && !branchValid;
    strobe.advFlow = flowIssue && !branchValid;
  end
endmodule

// File: rtl/seq_path.sv
module seq_path
  import seq_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              LEN_W      = 6,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] branchTarget,
  input  logic [LEN_W-1:0]  exuLen,
  input  logic [LEN_W-1:0]  flowLen,
  output logic [ADDR_W-1:0] exuAddr,
  output logic [ADDR_W-1:0] flowAddr
);
  localparam int PAD_W = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] exuPc, flowPc;
  logic [ADDR_W-1:0] exuStep, flowStep;

  assign exuStep  = {{PAD_W{1'b0}}, exuLen};
  assign flowStep = {{PAD_W{1'b0}}, flowLen};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      exuPc  <= RESET_ADDR;
      flowPc <= RESET_ADDR;
    end else if (strobe.load) begin
      exuPc  <= branchTarget;
      flowPc <= branchTarget;
    end else begin
      if (strobe.advExu)  exuPc  <= exuPc + exuStep;
      if (strobe.advFlow) flowPc <= flowPc - flowStep;
    end
  end

  assign exuAddr  = exuPc;
  assign flowAddr = flowPc - 1'b1;
endmodule

// File: rtl/dual_stream_seq.sv
module dual_stream_seq
  import seq_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              LEN_W      = 6,
  parameter int              SKIP_W     = 3,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 16'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  logic              branchValid,
  input  logic [ADDR_W-1:0] branchTarget,
  input  logic [LEN_W-1:0]  exuLen,
  input  logic [LEN_W-1:0]  flowLen,
  input  logic [SKIP_W-1:0] exuSkip,
  input  logic [SKIP_W-1:0] flowSkip,
  output logic [ADDR_W-1:0] exuAddr,
  output logic [ADDR_W-1:0] flowAddr,
  output logic              exuIssue,
  output logic              flowIssue
);
  seqStrobe_t strobe;

  seq_ctrl #(.SKIP_W(SKIP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .stall(stall), .branchValid(branchValid),
    .exuSkip(exuSkip), .flowSkip(flowSkip), .strobe(strobe),
    .exuIssue(exuIssue), .flowIssue(flowIssue)
  );

  seq_path #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .RESET_ADDR(RESET_ADDR)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .branchTarget(branchTarget),
    .exuLen(exuLen), .flowLen(flowLen), .exuAddr(exuAddr), .flowAddr(flowAddr)
  );
endmodule

// File: rtl/dual_stream_seq_chk.sv
module dual_stream_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 6,
  parameter int SKIP_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              stall,
  input logic              branchValid,
  input logic [ADDR_W-1:0] branchTarget,
  input logic [LEN_W-1:0]  exuLen,
  input logic [LEN_W-1:0]  flowLen,
  input logic [SKIP_W-1:0] exuSkip,
  input logic [SKIP_W-1:0] flowSkip,
  input logic [ADDR_W-1:0] exuAddr,
  input logic [ADDR_W-1:0] flowAddr,
  input logic              exuIssue,
  input logic              flowIssue
);
  assert_exu_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (exuIssue && !branchValid) |=>
      exuAddr == ADDR_W'($past(exuAddr) + ADDR_W'($past(exuLen))));

  assert_flow_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (flowIssue && !branchValid) |=>
      flowAddr == ADDR_W'($past(flowAddr) - ADDR_W'($past(flowLen))));

  assert_branch_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (branchValid && !stall) |=>
      (exuAddr == $past(branchTarget)) &&
      (flowAddr == ADDR_W'($past(branchTarget) - 1'b1)));

  assert_branch_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (branchValid && !stall) |=> (stall || (exuIssue && flowIssue)));

  assert_flow_mute_R6: assert property (@(posedge clk) disable iff (!rstN)
    (exuIssue && flowIssue && !branchValid && exuSkip != '0) |=> !flowIssue);

  assert_exu_mute_R7: assert property (@(posedge clk) disable iff (!rstN)
    (exuIssue && flowIssue && !branchValid && flowSkip != '0) |=> !exuIssue);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!exuIssue && !branchValid) |=> $stable(exuAddr));

  assert_stall_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (!exuIssue && !flowIssue));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(exuAddr) && $stable(flowAddr)));
endmodule

bind dual_stream_seq dual_stream_seq_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SKIP_W(SKIP_W)
) u_chk (.*);

// File: tb/tb_dual_stream_seq.sv
`timescale 1ns/1ps
module tb_dual_stream_seq;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 6;
  localparam int SKIP_W = 3;
  localparam int RST_A  = 'h1000;
  localparam int MASK   = (1 << ADDR_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stall = 1'b0, branchValid = 1'b0;
  logic [ADDR_W-1:0] branchTarget = '0;
  logic [LEN_W-1:0]  exuLen = '0, flowLen = '0;
  logic [SKIP_W-1:0] exuSkip = '0, flowSkip = '0;
  logic [ADDR_W-1:0] exuAddr, flowAddr;
  logic exuIssue, flowIssue;

  always #2.5 clk = ~clk;

  dual_stream_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SKIP_W(SKIP_W),
                    .RESET_ADDR(16'h1000)) dut (.*);

  // behavioural reference state
  int ePc, fPc, eIdle, fIdle;
  int vectors = 0, errors = 0;
  bit done = 1'b0;
  string tag;

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(bit st, bit br, int tgt, int el, int fl, int es, int fs);
    bit expE, expF;
    int nf, ne;
    @(negedge clk);
    stall = st; branchValid = br; branchTarget = tgt[ADDR_W-1:0];
    exuLen = el[LEN_W-1:0]; flowLen = fl[LEN_W-1:0];
    exuSkip = es[SKIP_W-1:0]; flowSkip = fs[SKIP_W-1:0];
    #1;
    expE = !st && eIdle == 0;
    expF = !st && fIdle == 0;
    cmp("exuAddr", int'(exuAddr), ePc & MASK);
    cmp("flowAddr", int'(flowAddr), (fPc - 1) & MASK);
    cmp("exuIssue", int'(exuIssue), int'(expE));
    cmp("flowIssue", int'(flowIssue), int'(expF));
    if (!st) begin
      if (br) begin
        ePc = tgt & MASK; fPc = tgt & MASK; eIdle = 0; fIdle = 0;
      end else begin
        if (expE) ePc = (ePc + el) & MASK;
        if (expF) fPc = (fPc - fl) & MASK;
        nf = fIdle > 0 ? fIdle - 1 : (expE ? es : 0);
        ne = eIdle > 0 ? eIdle - 1 : (expF ? fs : 0);
        fIdle = nf; eIdle = ne;
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    ePc = RST_A; fPc = RST_A; eIdle = 0; fIdle = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tag = "R1 reset state";
    step(0, 0, 0, 0, 0, 0, 0);
    tag = "R2 R3 plain advance";
    step(0, 0, 0, 5, 7, 0, 0);
    step(0, 0, 0, 63, 1, 0, 0);
    step(0, 0, 0, 12, 40, 0, 0);
    tag = "R4 R11 branch to zero";
    step(0, 1, 0, 9, 9, 0, 0);
    step(0, 0, 0, 4, 6, 0, 0);
    tag = "R11 wrap past top";
    step(0, 1, 'hFFFE, 0, 0, 0, 0);
    step(0, 0, 0, 4, 3, 0, 0);
    step(0, 0, 0, 1, 1, 0, 0);
    tag = "R6 R9 flow muted by exu skip";
    step(0, 0, 0, 8, 8, 3, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 2, 30, 0, 0);
    tag = "R7 R9 exu muted by flow skip";
    step(0, 0, 0, 8, 8, 0, 2);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 20, 3, 0, 0);
    tag = "R8 skip ignored while idle";
    step(0, 0, 0, 4, 4, 2, 0);
    step(0, 0, 0, 4, 4, 7, 0);
    step(0, 0, 0, 4, 4, 7, 0);
    step(0, 0, 0, 4, 4, 0, 0);
    step(0, 0, 0, 4, 4, 0, 0);
    tag = "R8 both idle at once";
    step(0, 0, 0, 4, 4, 2, 3);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 4, 4, 0, 0);
    tag = "R10 stall inside skip window";
    step(0, 0, 0, 4, 4, 2, 0);
    step(1, 1, 'h2222, 4, 4, 5, 5);
    step(1, 0, 0, 4, 4, 5, 5);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 4, 4, 0, 0);
    tag = "R5 branch clears pending skip";
    step(0, 0, 0, 4, 4, 6, 5);
    step(0, 1, 'h4000, 4, 4, 0, 0);
    step(0, 0, 0, 4, 4, 0, 0);
    tag = "random mix";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 15);
      step(r == 0, r == 1, $urandom_range(0, MASK), $urandom_range(0, 63),
           $urandom_range(0, 63),
           ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0,
           ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule